// File: doc/BRIEF.md
# Clock-Ready Interrupt Register

This block is the interrupt register of a clock controller. It watches five clock sources: a PLL lock indication and four oscillator ready indications. The oscillators are an external high-speed one, an internal high-speed RC one, an external low-speed crystal and an internal low-speed RC one. It also watches a failure indication from a clock security monitor.

Software writes per-source enable bits through a single 32-bit register. A ready flag latches when its source rises and its enable is set. The failure flag latches whenever failure is reported and cannot be masked. Flags are cleared only through separate write-one clear bits. The request line `irq` is the OR of all flags. The failure flag also drives a non-maskable request `nmi`.

The register port is a plain strobe. A write takes effect on the clock edge where `wr_en` is high. `rd_data` always shows the current register contents. No handshake or back-pressure is involved.

Top module: `clkrdy_irq_reg`

## Requirements
- R1: After reset, `rd_data`, `irq` and `nmi` are all 0.
- R2: Bits 12:8 hold read/write enables, 1 meaning enabled. Bit 12 is PLL, 11 external high-speed, 10 internal high-speed, 9 external low-speed and 8 internal low-speed.
- R3: A ready flag sets on the rising edge of its source only when its enable is 1. Bit 4 is PLL, 3 external high-speed, 2 internal high-speed, 1 external low-speed and 0 internal low-speed. The flag is visible in the cycle after the edge is sampled.
- R4: A source that stays high after its flag is cleared does not set the flag again.
- R5: Bit 7, the failure flag, sets in any cycle where `css_fail` is sampled high, regardless of the enables. `nmi` equals this flag.
- R6: Writing 1 clears a flag. Bit 23 clears the failure flag, and bits 20:16 clear bits 4:0 in order. Writing 0 to a clear bit, or writing to flag positions 7 and 4:0, has no effect.
- R7: Bits 31:13, 6:5 and the clear bits always read 0.
- R8: If a flag's set and its clear fall in the same cycle, the flag ends set.
- R9: `irq` is 1 exactly when any flag in bits 7 and 4:0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| pll_lock | input | 1 | PLL locked |
| hse_rdy | input | 1 | External high-speed oscillator stable |
| hsi_rdy | input | 1 | Internal high-speed RC stable |
| lse_rdy | input | 1 | External low-speed crystal stable |
| lsi_rdy | input | 1 | Internal low-speed RC stable |
| css_fail | input | 1 | Clock security failure detected |
| irq | output | 1 | Interrupt request, OR of all flags |
| nmi | output | 1 | Non-maskable request from the failure flag |

## Verification
A hardware set of a flag and a software clear of the same flag can land in the same cycle. The bench provokes this twice. In one case it holds `css_fail` high while writing the failure clear bit. In the other it raises the PLL and external high-speed sources in the same cycle as a write to the PLL clear bit. The scoreboard expects both flags to end set, with `irq` high. Steady-high sources across clears are also judged, to show that clearing does not refire a flag.

// File: rtl/clkrdy_pkg.sv
package clkrdy_pkg;
  localparam int unsigned NSRC     = 5;   // lsi, lse, hsi, hse, pll
  localparam int unsigned DW       = 32;
  localparam int unsigned EN_LSB   = 8;
  localparam int unsigned FAIL_BIT = 7;
  localparam int unsigned RDY_LSB  = 0;
  localparam int unsigned CLR_LSB  = 16;
  localparam int unsigned FCLR_BIT = 23;
endpackage

// File: rtl/clkrdy_edge.sv
module clkrdy_edge #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R4: a steady level yields one rise only
    p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/clkrdy_flag.sv
module clkrdy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/clkrdy_irq_reg.sv
module clkrdy_irq_reg
  import clkrdy_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          pll_lock,
  input  logic          hse_rdy,
  input  logic          hsi_rdy,
  input  logic          lse_rdy,
  input  logic          lsi_rdy,
  input  logic          css_fail,
  output logic          irq,
  output logic          nmi
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] src_lvl;
  logic [NSRC-1:0] src_rise;
  logic [NSRC-1:0] rdy_flag;
  logic [NSRC-1:0] rdy_clr;
  logic            fail_flag;
  logic            fail_clr;

  assign src_lvl  = {pll_lock, hse_rdy, hsi_rdy, lse_rdy, lsi_rdy};
  assign rdy_clr  = wr_en ? wr_data[CLR_LSB +: NSRC] : '0;
  assign fail_clr = wr_en & wr_data[FCLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[EN_LSB +: NSRC];
  end

  clkrdy_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(src_lvl), .rise_o(src_rise)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_rdy
    clkrdy_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(src_rise[i] & en_q[i]),
      .clr_i(rdy_clr[i]),
      .flag_o(rdy_flag[i])
    );
    // R3: a ready flag only rises while its enable was set
    p_rdy_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[RDY_LSB+i]) |-> $past(rd_data[EN_LSB+i]));
  end

  clkrdy_flag u_fail (
    .clk(clk), .rst_n(rst_n),
    .set_i(css_fail), .clr_i(fail_clr), .flag_o(fail_flag)
  );

  always_comb begin
    rd_data                    = '0;
    rd_data[EN_LSB +: NSRC]    = en_q;
    rd_data[FAIL_BIT]          = fail_flag;
    rd_data[RDY_LSB +: NSRC]   = rdy_flag;
  end

  assign irq = fail_flag | (|rdy_flag);
  assign nmi = fail_flag;

  p_nmi_implies_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> irq);
  p_fail_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    css_fail |=> nmi);
endmodule

// File: tb/clkrdy_irq_reg_test.sv
module clkrdy_irq_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pll_lock = 0, hse_rdy = 0, hsi_rdy = 0, lse_rdy = 0, lsi_rdy = 0, css_fail = 0;
  logic        irq, nmi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    logic        nmi;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  clkrdy_irq_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_lock(pll_lock), .hse_rdy(hse_rdy), .hsi_rdy(hsi_rdy), .lse_rdy(lse_rdy),
    .lsi_rdy(lsi_rdy), .css_fail(css_fail), .irq(irq), .nmi(nmi)
  );

  // monitor: compares each expected item at the negedge after it was queued
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (rd_data !== e.rd || irq !== e.irq || nmi !== e.nmi) begin
          bad++;
          $display("FAIL %s: rd=%h irq=%b nmi=%b expected rd=%h irq=%b nmi=%b",
                   e.req, rd_data, irq, nmi, e.rd, e.irq, e.nmi);
        end
      end
    end
  end

  task automatic expect_st(input logic [31:0] rd, input logic i, input logic n, input string req);
    exp_t e;
    e.rd = rd; e.irq = i; e.nmi = n; e.req = req;
    sb.push_back(e);
  endtask

  // apply current inputs for one edge; optional write
  task automatic tick(input logic w, input logic [31:0] d);
    wr_en = w; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_st(32'h0, 0, 0, "R1 reset state");
    @(negedge clk);
    rst_n = 1; #1;

    tick(1, 32'h0000_1F00);
    expect_st(32'h0000_1F00, 0, 0, "R2 all enables read back");
    tick(1, 32'h0000_0A00);
    expect_st(32'h0000_0A00, 0, 0, "R2 hse+lse enables");

    lse_rdy = 1; hsi_rdy = 1;
    tick(0, 0);
    expect_st(32'h0000_0A02, 1, 0, "R3 lse set, hsi masked, R9 irq");

    tick(1, 32'h0002_0A00);
    expect_st(32'h0000_0A00, 0, 0, "R6 lse cleared");
    tick(0, 0);
    expect_st(32'h0000_0A00, 0, 0, "R4 steady lse does not refire");

    tick(1, 32'h0000_0A9F);
    expect_st(32'h0000_0A00, 0, 0, "R6 flag positions ignored");

    css_fail = 1;
    tick(0, 0);
    expect_st(32'h0000_0A80, 1, 1, "R5 failure flag unmasked");
    tick(1, 32'h0080_0A00);
    expect_st(32'h0000_0A80, 1, 1, "R8 failure set beats clear");
    css_fail = 0;
    tick(1, 32'h0000_0A00);
    expect_st(32'h0000_0A80, 1, 1, "R6 zero clear bits no effect");
    tick(1, 32'h0080_0A00);
    expect_st(32'h0000_0A00, 0, 0, "R6 failure cleared");

    tick(1, 32'hFFE0_1F00);
    expect_st(32'h0000_1F00, 0, 0, "R7 upper and clear bits read 0");

    pll_lock = 1; hse_rdy = 1;
    tick(1, 32'h0010_1F00);
    expect_st(32'h0000_1F18, 1, 0, "R8 pll set beats clear, R3 hse set");

    pll_lock = 0; hse_rdy = 0; hsi_rdy = 0; lse_rdy = 0;
    tick(1, 32'h001F_1F00);
    expect_st(32'h0000_1F00, 0, 0, "R6 all ready flags cleared, R9 irq low");

    lsi_rdy = 1;
    tick(0, 0);
    expect_st(32'h0000_1F01, 1, 0, "R3 lsi set, R9 irq");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule